// File: doc/BRIEF.md
# Command Method Decoder and Validator

This block sits behind a command FIFO and takes one method write per cycle: a byte address and a 32-bit data word. It finds the address in a fixed set of method ranges. Each matched method has its own mask of legal data bits and one of three actions. The action stores the word in the state register file, stores it in a DMA object slot, or raises a one-cycle command strobe for execute or write-cache flush.

An address outside every range, or a word with a bit set outside the method's legal mask, is an exception. The block records an exception code with the address in one scratch register and the data word in another. It then raises a host interrupt. No further methods are accepted until the host clears the interrupt. A separate read port returns the stored value for any state or DMA method address, so the host can see the state.

Top module: `cmd_method_decoder`

## Requirements
- R1: After reset, mthdReady is 1. irqPending, execStrobe and flushStrobe are 0. Both scratch registers read 0, and every state and DMA method address reads back 0.
- R2: A method is accepted only in a cycle where mthdValid and mthdReady are both 1. A legal state method write is readable through rdAddr/rdData, with the same address, from the cycle after acceptance.
- R3: Addresses 0x180 + 4*k, for k from 0 to DMA_SLOTS-1, write DMA slot k with all 32 bits legal. The first aligned address past the last slot is illegal.
- R4: An address that is misaligned (bits [1:0] not 0) or lies in no range is an illegal method. The cycle after acceptance, irqPending is 1. Scratch0 = {8'h01, 8'h00, address[15:0]} and scratch1 = the data word.
- R5: A word with any bit set outside its method's legal mask is an invalid bitfield. Scratch0 = {8'h02, 8'h00, address}, scratch1 = data, irqPending rises, and the stored value is left unchanged.
- R6: Source tiling occupies 0x200–0x218 and destination tiling 0x220–0x238, both in this order: mode 0xFFF, width 0x7FFFF, height 0x1FFF, depth 0x7FF, depth offset 0xFFF, x offset 0x7FFFF, y offset 0x1FFF. The misc range 0x30C–0x340 holds, in order: source address high 0xFF, source address low 0xFFFFFFF0, destination address high 0xFF, destination address low 0xFFFFFFF0, source pitch 0x7FFFF, destination pitch 0x7FFFF, x count 0xFFFF, y count 0x1FFF, format 0x0333FFFF, then five full 32-bit words (two swizzle constants, query address high 0xFF, query address low and query counter full). Query address high is the exception to the full width.
- R7: Addresses with a full 32-bit legal mask accept the value 0xFFFFFFFF without an exception.
- R8: A write to 0x300 pulses execStrobe, and a write to 0x304 pulses flushStrobe. Each pulse lasts exactly one cycle, comes the cycle after acceptance, and changes no stored state. Back-to-back commands give one pulse each.
- R9: irqPending stays 1, and mthdReady stays 0, until a cycle with irqClear. mthdReady returns to 1 the cycle after that. While the interrupt is pending, mthdValid is ignored and the scratch registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mthdValid | input | 1 | Method write offered |
| mthdAddr | input | ADDR_W | Method byte address |
| mthdData | input | 32 | Method data word |
| mthdReady | output | 1 | Method write can be taken |
| irqClear | input | 1 | Host clear of the pending interrupt |
| rdAddr | input | ADDR_W | Method address to read back |
| rdData | output | 32 | Stored value at rdAddr, 0 if none |
| execStrobe | output | 1 | One-cycle execute command pulse |
| flushStrobe | output | 1 | One-cycle write-cache flush pulse |
| irqPending | output | 1 | Host interrupt |
| scratch0 | output | 32 | Exception code and method address |
| scratch1 | output | 32 | Method data of the exception |

## Verification
The bench uses the default parameters: ADDR_W of 16 and DMA_SLOTS of 4. With these values the last DMA slot sits at 0x18C, and 0x190 is the first illegal address past it. The gap word at 0x21C and the word past the misc range at 0x344 are also in reach. A vector is placed at each mask boundary, one legal at the top of the mask and one with the first bit above it set. The vectors also cover the stall while an interrupt is pending and back-to-back command pulses.

// File: rtl/cmd_method_pkg.sv
package cmd_method_pkg;

  localparam int DATA_W = 32;
  localparam int TILE_REGS = 7;
  localparam int MISC_REGS = 14;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_STATE,
    KIND_DMA,
    KIND_EXEC,
    KIND_FLUSH
  } mthdKind_e;

  localparam logic [7:0] CODE_ILLEGAL = 8'h01;
  localparam logic [7:0] CODE_BITFIELD = 8'h02;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrEn;
    logic       excEn;
    logic [7:0] code;
  } ctlStrobe_t;

  function automatic logic [DATA_W-1:0] tileMask(input int k);
    case (k)
      0: return 32'h0000_0FFF;
      1: return 32'h0007_FFFF;
      2: return 32'h0000_1FFF;
      3: return 32'h0000_07FF;
      4: return 32'h0000_0FFF;
      5: return 32'h0007_FFFF;
      default: return 32'h0000_1FFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] miscMask(input int k);
    case (k)
      0, 2, 11: return 32'h0000_00FF;
      1, 3:     return 32'hFFFF_FFF0;
      4, 5:     return 32'h0007_FFFF;
      6:        return 32'h0000_FFFF;
      7:        return 32'h0000_1FFF;
      8:        return 32'h0333_FFFF;
      default:  return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cmd_method_lookup.sv
module cmd_method_lookup
  import cmd_method_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DMA_SLOTS = 4,
  parameter int IDX_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output mthdKind_e         kind,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] mask
);
  localparam logic [31:0] DMA_BASE = 32'h180;
  localparam logic [31:0] DMA_END = DMA_BASE + 32'(4 * DMA_SLOTS);
  localparam logic [31:0] SRC_BASE = 32'h200;
  localparam logic [31:0] DST_BASE = 32'h220;
  localparam logic [31:0] MISC_BASE = 32'h30C;
  localparam logic [31:0] EXEC_ADDR = 32'h300;
  localparam logic [31:0] FLUSH_ADDR = 32'h304;
  localparam int SRC_IDX = DMA_SLOTS;
  localparam int DST_IDX = DMA_SLOTS + TILE_REGS;
  localparam int MISC_IDX = DMA_SLOTS + 2 * TILE_REGS;

  logic [31:0] wideAddr;
  logic [31:0] word;

  always_comb begin
    wideAddr = 32'(addr);
    hit = 1'b0;
    kind = KIND_NONE;
    idx = '0;
    mask = '1;
    word = '0;
    if (addr[1:0] == 2'b00) begin
      if (wideAddr >= DMA_BASE && wideAddr < DMA_END) begin
        word = (wideAddr - DMA_BASE) >> 2;
        hit = 1'b1;
        kind = KIND_DMA;
        idx = IDX_W'(word);
      end else if (wideAddr >= SRC_BASE && wideAddr < SRC_BASE + 32'(4 * TILE_REGS)) begin
        word = (wideAddr - SRC_BASE) >> 2;
        hit = 1'b1;
        kind = KIND_STATE;
        idx = IDX_W'(SRC_IDX + int'(word));
        mask = tileMask(int'(word));
      end else if (wideAddr >= DST_BASE && wideAddr < DST_BASE + 32'(4 * TILE_REGS)) begin
        word = (wideAddr - DST_BASE) >> 2;
        hit = 1'b1;
        kind = KIND_STATE;
        idx = IDX_W'(DST_IDX + int'(word));
        mask = tileMask(int'(word));
      end else if (wideAddr == EXEC_ADDR) begin
        hit = 1'b1;
        kind = KIND_EXEC;
      end else if (wideAddr == FLUSH_ADDR) begin
        hit = 1'b1;
        kind = KIND_FLUSH;
      end else if (wideAddr >= MISC_BASE && wideAddr < MISC_BASE + 32'(4 * MISC_REGS)) begin
        word = (wideAddr - MISC_BASE) >> 2;
        hit = 1'b1;
        kind = KIND_STATE;
        idx = IDX_W'(MISC_IDX + int'(word));
        mask = miscMask(int'(word));
      end
    end
  end

endmodule

// File: rtl/cmd_method_ctrl.sv
module cmd_method_ctrl
  import cmd_method_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              mthdValid,
  input  logic [DATA_W-1:0] mthdData,
  input  logic              irqClear,
  input  logic              hit,
  input  mthdKind_e         kind,
  input  logic [DATA_W-1:0] mask,
  output ctlStrobe_t        ctl,
  output logic              irqPending,
  output logic              execStrobe,
  output logic              flushStrobe
);
  logic accept;
  logic badBits;
  logic good;
  logic irqQ;
  logic execQ;
  logic flushQ;

  always_comb begin
    accept = mthdValid && !irqQ;
    badBits = |(mthdData & ~mask);
    good = accept && hit && !badBits;
    ctl.wrEn = good && (kind == KIND_STATE || kind == KIND_DMA);
    ctl.excEn = accept && (!hit || badBits);
    ctl.code = hit ? CODE_BITFIELD : CODE_ILLEGAL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ <= 1'b0;
      execQ <= 1'b0;
      flushQ <= 1'b0;
    end else begin
      if (ctl.excEn) irqQ <= 1'b1;
      else if (irqClear) irqQ <= 1'b0;
      execQ <= good && kind == KIND_EXEC;
      flushQ <= good && kind == KIND_FLUSH;
    end
  end

  assign irqPending = irqQ;
  assign execStrobe = execQ;
  assign flushStrobe = flushQ;

endmodule

// File: rtl/cmd_method_store.sv
module cmd_method_store
  import cmd_method_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_REGS = 32,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] mthdAddr,
  input  logic [DATA_W-1:0] mthdData,
  input  logic              rdHit,
  input  mthdKind_e         rdKind,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] scratch0,
  output logic [DATA_W-1:0] scratch1
);
  logic [DATA_W-1:0] stateQ [NUM_REGS];
  logic [DATA_W-1:0] scr0Q;
  logic [DATA_W-1:0] scr1Q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) stateQ[g] <= '0;
      else if (ctl.wrEn && wrIdx == IDX_W'(g)) stateQ[g] <= mthdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scr0Q <= '0;
      scr1Q <= '0;
    end else if (ctl.excEn) begin
      scr0Q <= {ctl.code, 8'h00, 16'(mthdAddr)};
      scr1Q <= mthdData;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdHit && (rdKind == KIND_STATE || rdKind == KIND_DMA) && int'(rdIdx) < NUM_REGS)
      rdData = stateQ[rdIdx];
  end

  assign scratch0 = scr0Q;
  assign scratch1 = scr1Q;

endmodule

// File: rtl/cmd_method_decoder.sv
module cmd_method_decoder
  import cmd_method_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DMA_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mthdValid,
  input  logic [ADDR_W-1:0] mthdAddr,
  input  logic [31:0]       mthdData,
  output logic              mthdReady,
  input  logic              irqClear,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              execStrobe,
  output logic              flushStrobe,
  output logic              irqPending,
  output logic [31:0]       scratch0,
  output logic [31:0]       scratch1
);
  localparam int NUM_REGS = DMA_SLOTS + 2 * TILE_REGS + MISC_REGS;
  localparam int IDX_W = $clog2(NUM_REGS + 1);

  logic              wrHit;
  mthdKind_e         wrKind;
  logic [IDX_W-1:0]  wrIdx;
  logic [DATA_W-1:0] wrMask;
  logic              rdHit;
  mthdKind_e         rdKind;
  logic [IDX_W-1:0]  rdIdx;
  logic [DATA_W-1:0] rdMask;
  ctlStrobe_t        ctl;

  cmd_method_lookup #(.ADDR_W(ADDR_W), .DMA_SLOTS(DMA_SLOTS), .IDX_W(IDX_W)) wrLook_i (
    .addr(mthdAddr), .hit(wrHit), .kind(wrKind), .idx(wrIdx), .mask(wrMask)
  );

  cmd_method_lookup #(.ADDR_W(ADDR_W), .DMA_SLOTS(DMA_SLOTS), .IDX_W(IDX_W)) rdLook_i (
    .addr(rdAddr), .hit(rdHit), .kind(rdKind), .idx(rdIdx), .mask(rdMask)
  );

  cmd_method_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .mthdValid(mthdValid), .mthdData(mthdData),
    .irqClear(irqClear), .hit(wrHit), .kind(wrKind), .mask(wrMask),
    .ctl(ctl), .irqPending(irqPending), .execStrobe(execStrobe),
    .flushStrobe(flushStrobe)
  );

  cmd_method_store #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) store_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrIdx(wrIdx), .mthdAddr(mthdAddr),
    .mthdData(mthdData), .rdHit(rdHit), .rdKind(rdKind), .rdIdx(rdIdx),
    .rdData(rdData), .scratch0(scratch0), .scratch1(scratch1)
  );

  assign mthdReady = !irqPending;

endmodule

// File: rtl/cmd_method_decoder_chk.sv
module cmd_method_decoder_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              mthdValid,
  input logic [ADDR_W-1:0] mthdAddr,
  input logic              mthdReady,
  input logic              irqClear,
  input logic              execStrobe,
  input logic              flushStrobe,
  input logic              irqPending,
  input logic [31:0]       scratch0,
  input logic [31:0]       scratch1
);
  a_r9_stall_while_pending: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> !mthdReady);

  a_r9_irq_held: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !irqClear) |=> irqPending);

  a_r9_scratch_held: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !irqClear) |=> ($stable(scratch0) && $stable(scratch1)));

  a_r8_exec_source: assert property (@(posedge clk) disable iff (!rstN)
    execStrobe |-> $past(mthdValid && mthdReady && 32'(mthdAddr) == 32'h300));

  a_r8_flush_source: assert property (@(posedge clk) disable iff (!rstN)
    flushStrobe |-> $past(mthdValid && mthdReady && 32'(mthdAddr) == 32'h304));

  a_r8_one_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({execStrobe, flushStrobe, $rose(irqPending)}));
endmodule

bind cmd_method_decoder cmd_method_decoder_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .mthdValid(mthdValid), .mthdAddr(mthdAddr),
  .mthdReady(mthdReady), .irqClear(irqClear), .execStrobe(execStrobe),
  .flushStrobe(flushStrobe), .irqPending(irqPending), .scratch0(scratch0),
  .scratch1(scratch1)
);

// File: tb/cmd_method_decoder_tb_top.sv
module cmd_method_decoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mthdValid = 1'b0;
  logic [15:0] mthdAddr = '0;
  logic [31:0] mthdData = '0;
  logic irqClear = 1'b0;
  logic [15:0] rdAddr = '0;
  logic mthdReady, execStrobe, flushStrobe, irqPending;
  logic [31:0] rdData, scratch0, scratch1;
  int testCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cmd_method_decoder dut_i (
    .clk(clk), .rstN(rstN), .mthdValid(mthdValid), .mthdAddr(mthdAddr),
    .mthdData(mthdData), .mthdReady(mthdReady), .irqClear(irqClear),
    .rdAddr(rdAddr), .rdData(rdData), .execStrobe(execStrobe),
    .flushStrobe(flushStrobe), .irqPending(irqPending),
    .scratch0(scratch0), .scratch1(scratch1)
  );

  // kinds: 0 store, 1 exec, 2 flush, 3 illegal, 4 bad bits
  typedef struct packed {
    logic [15:0] a;
    logic [31:0] d;
    logic [2:0]  k;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{16'h0200, 32'h0000_0ABC, 3'd0, 32'h0000_0ABC},
    '{16'h0200, 32'h0000_1000, 3'd4, 32'h0000_0ABC},
    '{16'h0204, 32'h0007_FFFF, 3'd0, 32'h0007_FFFF},
    '{16'h0204, 32'h0008_0000, 3'd4, 32'h0007_FFFF},
    '{16'h0218, 32'h0000_1FFF, 3'd0, 32'h0000_1FFF},
    '{16'h0238, 32'h0000_2000, 3'd4, 32'h0000_0000},
    '{16'h022C, 32'h0000_07FF, 3'd0, 32'h0000_07FF},
    '{16'h0310, 32'h1234_5670, 3'd0, 32'h1234_5670},
    '{16'h0310, 32'h1234_5678, 3'd4, 32'h1234_5670},
    '{16'h032C, 32'h0333_FFFF, 3'd0, 32'h0333_FFFF},
    '{16'h032C, 32'h0040_0000, 3'd4, 32'h0333_FFFF},
    '{16'h0338, 32'h0000_0100, 3'd4, 32'h0000_0000},
    '{16'h0330, 32'hFFFF_FFFF, 3'd0, 32'hFFFF_FFFF},
    '{16'h0340, 32'hFFFF_FFFF, 3'd0, 32'hFFFF_FFFF},
    '{16'h0180, 32'h1111_1111, 3'd0, 32'h1111_1111},
    '{16'h018C, 32'hFFFF_FFFF, 3'd0, 32'hFFFF_FFFF},
    '{16'h0190, 32'h0000_0005, 3'd3, 32'h0000_0000},
    '{16'h0300, 32'h0000_CAFE, 3'd1, 32'h0000_0000},
    '{16'h0304, 32'h0000_0001, 3'd2, 32'h0000_0000},
    '{16'h021C, 32'h0000_0001, 3'd3, 32'h0000_0000},
    '{16'h0202, 32'h0000_0001, 3'd3, 32'h0000_0000},
    '{16'h0344, 32'h0000_0007, 3'd3, 32'h0000_0000},
    '{16'h0324, 32'h0001_0000, 3'd4, 32'h0000_0000},
    '{16'h0324, 32'h0000_FFFF, 3'd0, 32'h0000_FFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendMthd(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    mthdValid = 1'b1;
    mthdAddr = a;
    mthdData = d;
    @(negedge clk);
    mthdValid = 1'b0;
  endtask

  task automatic clearIrq();
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
    check("R9 irq cleared", 32'(irqPending), 32'd0);
    check("R9 ready back", 32'(mthdReady), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", 32'(mthdReady), 32'd1);
    check("R1 irq", 32'(irqPending), 32'd0);
    check("R1 strobes", {30'd0, execStrobe, flushStrobe}, 32'd0);
    check("R1 scratch0", scratch0, 32'd0);
    check("R1 scratch1", scratch1, 32'd0);
    for (int i = 0; i < NV; i++) begin
      rdAddr = VEC[i].a;
      #0;
      check("R1 state zero", (VEC[i].k == 3'd0) ? rdData : 32'd0, 32'd0);
    end

    // vector table: R2 R3 R5 R6 R7 R8 R4
    for (int i = 0; i < NV; i++) begin
      rdAddr = VEC[i].a;
      sendMthd(VEC[i].a, VEC[i].d);
      case (VEC[i].k)
        3'd0: begin
          check("R2/R6 no irq", 32'(irqPending), 32'd0);
          check("R2 R3 R7 stored", rdData, VEC[i].e);
        end
        3'd1: begin
          check("R8 exec pulse", {31'd0, execStrobe}, 32'd1);
          check("R8 no flush", {31'd0, flushStrobe}, 32'd0);
          @(negedge clk);
          check("R8 exec one cycle", {31'd0, execStrobe}, 32'd0);
        end
        3'd2: begin
          check("R8 flush pulse", {31'd0, flushStrobe}, 32'd1);
          check("R8 no exec", {31'd0, execStrobe}, 32'd0);
          @(negedge clk);
          check("R8 flush one cycle", {31'd0, flushStrobe}, 32'd0);
        end
        3'd3: begin
          check("R4 irq", 32'(irqPending), 32'd1);
          check("R4 scratch0", scratch0, {8'h01, 8'h00, VEC[i].a});
          check("R4 scratch1", scratch1, VEC[i].d);
          check("R9 ready low", 32'(mthdReady), 32'd0);
          clearIrq();
        end
        default: begin
          check("R5 irq", 32'(irqPending), 32'd1);
          check("R5 scratch0", scratch0, {8'h02, 8'h00, VEC[i].a});
          check("R5 scratch1", scratch1, VEC[i].d);
          check("R5 R6 not stored", rdData, VEC[i].e);
          clearIrq();
        end
      endcase
    end

    // R8 commands leave state alone
    rdAddr = 16'h0200;
    #0;
    check("R8 state untouched", rdData, 32'h0000_0ABC);

    // R8 back-to-back commands
    @(negedge clk);
    mthdValid = 1'b1; mthdAddr = 16'h0300; mthdData = 32'd0;
    @(negedge clk);
    check("R8 first exec", {31'd0, execStrobe}, 32'd1);
    @(negedge clk);
    mthdValid = 1'b0;
    check("R8 second exec", {31'd0, execStrobe}, 32'd1);
    @(negedge clk);
    check("R8 exec ends", {31'd0, execStrobe}, 32'd0);

    // R9 stall while pending
    sendMthd(16'h0100, 32'hA5A5_0001);
    repeat (4) @(negedge clk);
    check("R9 still pending", 32'(irqPending), 32'd1);
    rdAddr = 16'h0204;
    mthdValid = 1'b1; mthdAddr = 16'h0204; mthdData = 32'h0000_0011;
    @(negedge clk);
    mthdValid = 1'b0;
    check("R9 write ignored", rdData, 32'h0007_FFFF);
    check("R9 scratch0 held", scratch0, {8'h01, 8'h00, 16'h0100});
    check("R9 scratch1 held", scratch1, 32'hA5A5_0001);
    clearIrq();
    sendMthd(16'h0204, 32'h0000_0022);
    check("R9 accepts after clear", rdData, 32'h0000_0022);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule